// File: doc/BRIEF.md
# Lookup-Table I/Q Waveform Sequencer

This block generates a digital local-oscillator waveform by replaying stored samples. There is no phase accumulator and no sine arithmetic. Two sample memories hold the in-phase and the quadrature waveforms, and one free-running address counter reads both at the same time. Each clock, the block presents one 8-bit sign-magnitude code per channel to a downstream multiplying DAC. The most significant bit is the sign, and it also serves as the chopper or LO drive of the mixer. Since the stored samples and the sequence length are free to choose, any tone below half the shared clock rate can be produced from that one clock.

Before playback, software-side logic fills the memories through a serial shift port. Bits enter most significant first. Every eighth bit completes a byte, which goes to an auto-incrementing load address in the memory chosen by a select pin. A programmable terminal count sets the length of the played sequence. A one-cycle marker flags the last sample of every period. Each memory defaults to 1024 words. Setting the address width to 12 gives 4096 words per channel, which is 64 Kb in total.

Top module: `iq_wave_sequencer`

## Requirements
- R1: While reset is held or the playback enable is low (as sampled at the previous clock edge), both code outputs read 8'h00 (positive sign, zero magnitude) and the period marker is low.
- R2: With playback enabled, the codes appear one clock after the edge that samples the enable. They show the stored samples at indices 0, 1, 2 and so on, one index per clock, through a single register stage.
- R3: In every cycle the I code and the Q code come from the same memory index.
- R4: When the current index is greater than or equal to the terminal count, the next index is 0. This also holds when the terminal count is lowered below the running index.
- R5: The period marker is high exactly in the cycles whose codes come from an index greater than or equal to the terminal count; otherwise it is low.
- R6: Serial load runs while the write enable is high. Each clock with the strobe high shifts in one data bit, most significant bit first. The eighth bit completes a byte, which is written at the load address, and the load address then increments. Dropping the write enable returns both the load address and the bit count to 0.
- R7: The select pin, sampled with the eighth bit, routes the byte to the Q memory when 1 and to the I memory when 0.
- R8: Strobes given while playback is enabled are ignored: no memory word changes, and neither the bit count nor the load address advances.
- R9: Disabling playback returns the read index to 0, so the next enable starts again at index 0.
- R10: Stored bytes reach the outputs unaltered. Bit 7 is the sign (1 selects the negative path) and bits 6:0 are the binary magnitude.
- R11: With a terminal count of 0, the same index-0 sample repeats every cycle and the period marker is high in every playback cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared central clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| play_en_i | input | 1 | Playback enable |
| seq_last_i | input | ADDR_W | Terminal count (last index of the sequence) |
| ser_data_i | input | 1 | Serial load data bit |
| ser_strobe_i | input | 1 | Shift one bit this clock |
| ser_wr_en_i | input | 1 | Serial load session enable |
| ser_sel_q_i | input | 1 | Target memory: 1 = Q, 0 = I |
| i_code_o | output | 8 | In-phase sign-magnitude code |
| q_code_o | output | 8 | Quadrature sign-magnitude code |
| period_o | output | 1 | One-cycle marker on the last sample of a period |

## Verification
The hardest condition to reach is a write attempt during playback that leaves a half-finished shift state behind. The stimulus keeps the write enable high and sends a full byte of strobes while playback runs. It then stops playback and, without dropping the enable, sends one more byte. That byte has to land whole at index 0, and the next playback pass exposes it. A second hard case is lowering the terminal count below the running index mid-sequence. The stimulus changes it partway through a period so that the greater-or-equal wrap is taken rather than an exact match.

// File: rtl/iq_seq_pkg.sv
package iq_seq_pkg;

    localparam int unsigned CODE_W = 8;
    localparam int unsigned MAG_W  = CODE_W - 1;
    localparam int unsigned N_CH   = 2;

    typedef logic [CODE_W-1:0] code_t;

    // zero magnitude with the sign bit cleared (positive path)
    localparam code_t CODE_ZERO = '0;

    function automatic logic code_sign(input code_t c);
        return c[CODE_W-1];
    endfunction

endpackage

// File: rtl/iq_serial_loader.sv
module iq_serial_loader
    import iq_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              play_en_i,
    input  logic              wr_en_i,
    input  logic              strobe_i,
    input  logic              data_i,
    input  logic              sel_q_i,
    output logic              we_i_o,
    output logic              we_q_o,
    output logic [ADDR_W-1:0] waddr_o,
    output code_t             wdata_o
);

    localparam int unsigned CNT_W = $clog2(CODE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CODE_W - 1);

    typedef struct packed {
        logic [MAG_W-1:0]  shreg;
        logic [CNT_W-1:0]  bits;
        logic [ADDR_W-1:0] addr;
    } ld_state_t;

    ld_state_t st_d, st_q;
    logic      byte_done;
    logic      shift_ok;

    always_comb begin
        st_d      = st_q;
        byte_done = 1'b0;
        shift_ok  = wr_en_i && !play_en_i && strobe_i;
        if (!wr_en_i) begin
            st_d.shreg = '0;
            st_d.bits  = '0;
            st_d.addr  = '0;
        end else if (shift_ok) begin
            st_d.shreg = {st_q.shreg[MAG_W-2:0], data_i};
            if (st_q.bits == CNT_LAST) begin
                byte_done = 1'b1;
                st_d.bits = '0;
                st_d.addr = st_q.addr + 1'b1;
            end else begin
                st_d.bits = st_q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wdata_o = {st_q.shreg, data_i};
    assign waddr_o = st_q.addr;
    assign we_i_o  = byte_done && !sel_q_i;
    assign we_q_o  = byte_done && sel_q_i;

endmodule

// File: rtl/iq_addr_counter.sv
module iq_addr_counter #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              play_en_i,
    input  logic [ADDR_W-1:0] last_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              period_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              period;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.addr >= last_i);
        if (!play_en_i) begin
            st_d.addr   = '0;
            st_d.period = 1'b0;
        end else begin
            st_d.period = at_end;
            st_d.addr   = at_end ? '0 : st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o   = st_q.addr;
    assign period_o = st_q.period;

endmodule

// File: rtl/iq_wave_ram.sv
module iq_wave_ram
    import iq_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  code_t             wdata_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output code_t             rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    code_t mem [DEPTH];
    code_t rdata_d, rdata_q;

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_d = rd_en_i ? mem[raddr_i] : CODE_ZERO;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= CODE_ZERO;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/iq_wave_sequencer.sv
module iq_wave_sequencer
    import iq_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              play_en_i,
    input  logic [ADDR_W-1:0] seq_last_i,
    input  logic              ser_data_i,
    input  logic              ser_strobe_i,
    input  logic              ser_wr_en_i,
    input  logic              ser_sel_q_i,
    output logic [7:0]        i_code_o,
    output logic [7:0]        q_code_o,
    output logic              period_o
);

    logic              ld_we_i, ld_we_q;
    logic [ADDR_W-1:0] ld_addr;
    code_t             ld_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              ch_we [N_CH];
    code_t             ch_rd [N_CH];

    iq_serial_loader #(.ADDR_W(ADDR_W)) u_loader (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .play_en_i (play_en_i),
        .wr_en_i   (ser_wr_en_i),
        .strobe_i  (ser_strobe_i),
        .data_i    (ser_data_i),
        .sel_q_i   (ser_sel_q_i),
        .we_i_o    (ld_we_i),
        .we_q_o    (ld_we_q),
        .waddr_o   (ld_addr),
        .wdata_o   (ld_data)
    );

    // one counter addresses both channels
    iq_addr_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .play_en_i (play_en_i),
        .last_i    (seq_last_i),
        .addr_o    (rd_addr),
        .period_o  (period_o)
    );

    assign ch_we[0] = ld_we_i;
    assign ch_we[1] = ld_we_q;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        iq_wave_ram #(.ADDR_W(ADDR_W)) u_ram (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .we_i    (ch_we[ch]),
            .waddr_i (ld_addr),
            .wdata_i (ld_data),
            .rd_en_i (play_en_i),
            .raddr_i (rd_addr),
            .rdata_o (ch_rd[ch])
        );
    end

    assign i_code_o = ch_rd[0];
    assign q_code_o = ch_rd[1];

endmodule

// File: rtl/iq_seq_checker.sv
module iq_seq_checker #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              play_en_i,
    input logic [ADDR_W-1:0] seq_last_i,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              we_any,
    input logic [7:0]        i_code_o,
    input logic [7:0]        q_code_o,
    input logic              period_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !play_en_i |=> (i_code_o == 8'h00) && (q_code_o == 8'h00) && !period_o);

    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (play_en_i && rd_addr < seq_last_i) |=> (rd_addr == $past(rd_addr) + ONE));

    p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (play_en_i && rd_addr >= seq_last_i) |=> (rd_addr == '0));

    p_mark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (play_en_i && rd_addr >= seq_last_i) |=> period_o);

    p_nomark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (play_en_i && rd_addr < seq_last_i) |=> !period_o);

    p_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        play_en_i |-> !we_any);

    p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !play_en_i |=> (rd_addr == '0));

endmodule

bind iq_wave_sequencer iq_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .play_en_i  (play_en_i),
    .seq_last_i (seq_last_i),
    .rd_addr    (rd_addr),
    .we_any     (ld_we_i | ld_we_q),
    .i_code_o   (i_code_o),
    .q_code_o   (q_code_o),
    .period_o   (period_o)
);

// File: tb/test_iq_wave_sequencer.sv
`timescale 1ns/1ps
module test_iq_wave_sequencer;

    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              play_en = 1'b0;
    logic [ADDR_W-1:0] seq_last = '0;
    logic              ser_data = 1'b0;
    logic              ser_strobe = 1'b0;
    logic              ser_wr_en = 1'b0;
    logic              ser_sel = 1'b0;
    logic [7:0]        i_code, q_code;
    logic              period;

    always #2 clk = ~clk;

    iq_wave_sequencer #(.ADDR_W(ADDR_W)) i_iq_wave_sequencer (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .play_en_i    (play_en),
        .seq_last_i   (seq_last),
        .ser_data_i   (ser_data),
        .ser_strobe_i (ser_strobe),
        .ser_wr_en_i  (ser_wr_en),
        .ser_sel_q_i  (ser_sel),
        .i_code_o     (i_code),
        .q_code_o     (q_code),
        .period_o     (period)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    chk_on = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] ref_i [DEPTH];
    logic [7:0] ref_q [DEPTH];
    bit         bitq[$];
    int         m_idx = 0;
    int         m_ld_addr = 0;
    logic [7:0] exp_i = 8'h00, exp_q = 8'h00;
    logic       exp_per = 1'b0;

    always @(posedge clk) begin
        if (!rst_ni) begin
            m_idx = 0; m_ld_addr = 0; bitq.delete();
            exp_i = 8'h00; exp_q = 8'h00; exp_per = 1'b0;
        end else begin
            if (play_en) begin
                exp_i   = ref_i[m_idx];
                exp_q   = ref_q[m_idx];
                exp_per = (m_idx >= int'(seq_last));
                if (m_idx >= int'(seq_last)) m_idx = 0;
                else m_idx = m_idx + 1;
            end else begin
                exp_i = 8'h00; exp_q = 8'h00; exp_per = 1'b0; m_idx = 0;
            end
            if (!ser_wr_en) begin
                bitq.delete(); m_ld_addr = 0;
            end else if (!play_en && ser_strobe) begin
                bitq.push_back(ser_data);
                if (bitq.size() == 8) begin
                    logic [7:0] b;
                    for (int k = 0; k < 8; k++) b[7-k] = bitq[k];
                    if (ser_sel) ref_q[m_ld_addr] = b;
                    else ref_i[m_ld_addr] = b;
                    m_ld_addr = (m_ld_addr + 1) % DEPTH;
                    bitq.delete();
                end
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (i_code !== exp_i || q_code !== exp_q || period !== exp_per) begin
                errors++;
                $display("FAIL %s: got i=%h q=%h per=%b, expected i=%h q=%h per=%b",
                         cur_req, i_code, q_code, period, exp_i, exp_q, exp_per);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected <= 50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic sel);
        for (int k = 7; k >= 0; k--) begin
            @(negedge clk);
            ser_data = b[k]; ser_strobe = 1'b1; ser_sel = sel;
            @(negedge clk);
            ser_strobe = 1'b0;
        end
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) begin ref_i[k] = 8'h00; ref_q[k] = 8'h00; end
        idle(3);
        // R1: reset state
        checks++;
        if (i_code !== 8'h00 || q_code !== 8'h00 || period !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset got i=%h q=%h per=%b expected 00 00 0", i_code, q_code, period);
        end
        rst_ni = 1'b1;
        chk_on = 1;
        cur_req = "R1"; idle(5);

        // R6: load I memory, sign alternates (R10)
        cur_req = "R6";
        ser_wr_en = 1'b1;
        for (int k = 0; k < 16; k++)
            send_byte(((k % 2) != 0 ? 8'h80 : 8'h00) | 8'((k * 9 + 3) & 8'h7F), 1'b0);
        @(negedge clk); ser_wr_en = 1'b0;
        // R7: load Q memory with distinct contents
        cur_req = "R7";
        @(negedge clk); ser_wr_en = 1'b1;
        for (int k = 0; k < 16; k++)
            send_byte(((k % 4) < 2 ? 8'h80 : 8'h00) | 8'((k * 5 + 64) & 8'h7F), 1'b1);
        @(negedge clk); ser_wr_en = 1'b0;
        // R6: address restarts at 0 in a new session
        cur_req = "R6";
        @(negedge clk); ser_wr_en = 1'b1;
        send_byte(8'hFF, 1'b0);
        send_byte(8'h01, 1'b0);
        @(negedge clk); ser_wr_en = 1'b0;

        // R2 / R3 / R5 / R10: playback
        seq_last = ADDR_W'(15);
        @(negedge clk); play_en = 1'b1;
        cur_req = "R2";  idle(20);
        cur_req = "R5";  idle(20);
        cur_req = "R3";  idle(10);
        cur_req = "R10"; idle(10);

        // R8: strobes during playback are ignored
        cur_req = "R8";
        ser_wr_en = 1'b1;
        send_byte(8'hC3, 1'b0);
        idle(20);
        @(negedge clk); play_en = 1'b0;
        send_byte(8'h5A, 1'b0);
        @(negedge clk); ser_wr_en = 1'b0;
        @(negedge clk); play_en = 1'b1;
        idle(40);

        // R9: stop mid-period and restart from 0
        cur_req = "R9";
        idle(7);
        @(negedge clk); play_en = 1'b0;
        idle(2);
        play_en = 1'b1;
        idle(20);

        // R4: lower terminal count below the running index
        cur_req = "R4";
        @(negedge clk); play_en = 1'b0;
        @(negedge clk); play_en = 1'b1;
        idle(10);
        seq_last = ADDR_W'(3);
        idle(20);
        seq_last = ADDR_W'(9);
        idle(25);

        // R11: terminal count of zero
        cur_req = "R11";
        seq_last = '0;
        idle(12);

        cur_req = "R1";
        play_en = 1'b0;
        idle(6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule